// File: doc/BRIEF.md
# Bipolar Stepper Microstep Sequencer

This block tracks the electrical angle of a two-phase bipolar stepping motor. It turns each rising edge of an external step input into a move along a sine/cosine current profile. For each phase it drives a signed current demand, in percent of full scale, to the downstream chopper and bridge logic. A two-bit resolution select picks full step, half step, or eight or sixteen microsteps per quarter wave. A two-bit torque select scales both demands. A direction bit picks which way the profile is walked.

An active-low home input parks the sequencer at a fixed starting vector that depends on the resolution, and a flag reports when the position sits at that vector. The enable input only gates the demands and the bridge enable. While enable is low, steps still move the internal position, so output picks up at the advanced angle when enable returns high.

The step input is asynchronous to the system clock. It is synchronised and edge-detected inside the block. The demands are registered.

Top module: `stepper_seq`

## Requirements
- R1: The angle is held as an index p in 0..63 (64 positions per electrical cycle, 16 per quarter). The resolution select mode_i decides the stride per step: 00 is full step (stride 16, 4 steps per cycle), 01 is half step (stride 8), 10 is sixteen per quarter (stride 1), 11 is eight per quarter (stride 2).
- R2: Magnitude comes from one 17-entry quarter table, indexed by m (the distance from p to the nearest multiple of 32). Read from m = 16 down to m = 0, the table is 0, 10, 20, 29, 38, 47, 56, 63, 71, 77, 83, 88, 92, 96, 98, 100, 100. The eight-per-quarter and half-step modes read only its even entries.
- R3: In full-step mode both phases are driven at magnitude 100 with the sign of the profile. Walking forward from home gives (+100,-100), (+100,+100), (-100,+100), (-100,-100) and then wraps.
- R4: While home_ni is low, the index is loaded with the home vector: p = 56 in full-step mode, giving A = +100 and B = -100, and p = 0 otherwise, giving A = +100 and B = 0. step_i and dir_i have no effect.
- R5: After home_ni rises, the first step edge moves to the position one stride from home.
- R6: Phase A follows the cosine of p: negative for 16 < p < 48. Phase B is phase A delayed by one quarter wave, so B at p equals A at p - 16 (mod 64).
- R7: dir_i = 0 adds the stride on each step. dir_i = 1 subtracts it, so the profile is walked in reverse.
- R8: While enable_i is low, set_a_o, set_b_o and drive_en_o are 0 but steps keep moving p. When enable_i returns high, the demands resume at the moved position.
- R9: torque_i scales each magnitude before the sign is applied: 00 gives 100 %, 01 gives 75 %, 10 gives 50 %, 11 gives 20 %. The result is floor(magnitude × percent / 100).
- R10: at_home_o is 1 exactly when p equals the home index of the current mode, whether held there or reached by stepping.
- R11: Each rising edge of step_i counts once, however long step_i stays high, provided each level lasts at least 3 clocks. The demands show the new step on the third clock edge after the first edge that samples step_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; all outputs 0 |
| step_i | input | 1 | Asynchronous step input, rising edge advances |
| dir_i | input | 1 | 0 forward, 1 reverse |
| mode_i | input | 2 | Resolution select (R1) |
| torque_i | input | 2 | Current scale select (R9) |
| home_ni | input | 1 | Active-low hold at the home vector |
| enable_i | input | 1 | Active-high demand and bridge enable |
| set_a_o | output | SET_W | Signed phase A demand in percent |
| set_b_o | output | SET_W | Signed phase B demand in percent |
| at_home_o | output | 1 | Position is the home vector |
| drive_en_o | output | 1 | Bridge enable, registered copy of enable_i |

## Verification
A corrupted index or stride shows up on the next step as a demand pair that does not lie on the expected profile point. For example, phase B stops trailing A by a quarter, or at_home_o fails to return after a full cycle. It appears no later than three clocks after the synchronised edge. A wrong synchroniser or edge detector shows as doubled steps or missing steps, which the long-pulse and latency checks catch. A position that stops moving while enable is low only shows once enable is raised again, at the first comparison with the resumed demands.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int Q_FINE = 16;
  localparam int POS_N  = 4 * Q_FINE;
  localparam int POS_W  = $clog2(POS_N);
  localparam int R_W    = POS_W - 1;
  localparam int MAG_W  = 7;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_HALF = 2'b01,
    MODE_M16  = 2'b10,
    MODE_M8   = 2'b11
  } mode_e;

  // quarter-wave cosine magnitude, m = 0..Q_FINE
  function automatic logic [MAG_W-1:0] quarter_mag(input logic [R_W-1:0] m);
    case (m)
      5'd0, 5'd1: quarter_mag = 7'd100;
      5'd2:  quarter_mag = 7'd98;
      5'd3:  quarter_mag = 7'd96;
      5'd4:  quarter_mag = 7'd92;
      5'd5:  quarter_mag = 7'd88;
      5'd6:  quarter_mag = 7'd83;
      5'd7:  quarter_mag = 7'd77;
      5'd8:  quarter_mag = 7'd71;
      5'd9:  quarter_mag = 7'd63;
      5'd10: quarter_mag = 7'd56;
      5'd11: quarter_mag = 7'd47;
      5'd12: quarter_mag = 7'd38;
      5'd13: quarter_mag = 7'd29;
      5'd14: quarter_mag = 7'd20;
      5'd15: quarter_mag = 7'd10;
      default: quarter_mag = 7'd0;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] mode_stride(input mode_e md);
    case (md)
      MODE_FULL: mode_stride = POS_W'(Q_FINE);
      MODE_HALF: mode_stride = POS_W'(Q_FINE / 2);
      MODE_M8:   mode_stride = POS_W'(2);
      default:   mode_stride = POS_W'(1);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] home_pos(input mode_e md);
    home_pos = (md == MODE_FULL) ? POS_W'(POS_N - Q_FINE / 2) : '0;
  endfunction

  function automatic logic [MAG_W-1:0] torque_pct(input logic [1:0] tq);
    case (tq)
      2'b00:   torque_pct = 7'd100;
      2'b01:   torque_pct = 7'd75;
      2'b10:   torque_pct = 7'd50;
      default: torque_pct = 7'd20;
    endcase
  endfunction
endpackage

// File: rtl/step_edge.sv
module step_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b0;
      else if (g == 0) sh_q[g] <= step_i;
      else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_one_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/step_counter.sv
module step_counter
  import stepper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             home_ni,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  input  logic             rise_i,
  output logic [POS_W-1:0] pos_o
);
  mode_e            md;
  logic [POS_W-1:0] stride;

  assign md     = mode_e'(mode_i);
  assign stride = mode_stride(md);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_o <= '0;
    else if (!home_ni) pos_o <= home_pos(md);
    else if (rise_i)   pos_o <= dir_i ? pos_o - stride : pos_o + stride;
  end

  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    home_ni && !rise_i |=> $stable(pos_o));
endmodule

// File: rtl/wave_lookup.sv
module wave_lookup
  import stepper_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [1:0]       mode_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             neg_o
);
  logic [POS_W-1:0] p;
  logic [R_W-1:0]   r, m;

  assign p = pos_i - POS_W'(OFFSET);
  assign r = p[R_W-1:0];
  // fold the half period onto one quarter
  assign m = (r <= R_W'(Q_FINE)) ? r : R_W'(0) - r;
  assign neg_o = (p > POS_W'(Q_FINE)) && (p < POS_W'(3 * Q_FINE));

  always_comb begin
    case (mode_e'(mode_i))
      MODE_FULL: mag_o = (m == R_W'(Q_FINE)) ? '0 : 7'd100;
      MODE_M16:  mag_o = quarter_mag(m);
      default:   mag_o = quarter_mag({m[R_W-1:1], 1'b0});
    endcase
    p_mag_range_r2: assert (mag_o <= 7'd100);
  end
endmodule

// File: rtl/torque_scale.sv
module torque_scale
  import stepper_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic [MAG_W-1:0]        mag_i,
  input  logic                    neg_i,
  input  logic [1:0]              torque_i,
  output logic signed [SET_W-1:0] set_o
);
  localparam int PROD_W = 2 * MAG_W;

  logic [PROD_W-1:0]       prod;
  logic [MAG_W-1:0]        q;
  logic signed [SET_W-1:0] q_s;

  assign prod = PROD_W'(mag_i) * PROD_W'(torque_pct(torque_i));
  assign q    = MAG_W'(prod / PROD_W'(100));
  assign q_s  = $signed({{(SET_W-MAG_W){1'b0}}, q});
  assign set_o = neg_i ? -q_s : q_s;
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int SET_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    dir_i,
  input  logic [1:0]              mode_i,
  input  logic [1:0]              torque_i,
  input  logic                    home_ni,
  input  logic                    enable_i,
  output logic signed [SET_W-1:0] set_a_o,
  output logic signed [SET_W-1:0] set_b_o,
  output logic                    at_home_o,
  output logic                    drive_en_o
);
  localparam int N_PH = 2;

  logic                    step_rise;
  logic [POS_W-1:0]        pos;
  logic signed [SET_W-1:0] set_nx [N_PH];

  step_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .rise_o (step_rise)
  );

  step_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .home_ni (home_ni),
    .dir_i   (dir_i),
    .mode_i  (mode_i),
    .rise_i  (step_rise),
    .pos_o   (pos)
  );

  // phase g trails phase A by g quarter waves
  for (genvar g = 0; g < N_PH; g++) begin : g_phase
    logic [MAG_W-1:0] mag;
    logic             neg;

    wave_lookup #(.OFFSET(g * Q_FINE)) u_lut (
      .pos_i  (pos),
      .mode_i (mode_i),
      .mag_o  (mag),
      .neg_o  (neg)
    );

    torque_scale #(.SET_W(SET_W)) u_tq (
      .mag_i    (mag),
      .neg_i    (neg),
      .torque_i (torque_i),
      .set_o    (set_nx[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_a_o    <= '0;
      set_b_o    <= '0;
      at_home_o  <= 1'b0;
      drive_en_o <= 1'b0;
    end else begin
      set_a_o    <= enable_i ? set_nx[0] : '0;
      set_b_o    <= enable_i ? set_nx[1] : '0;
      at_home_o  <= (pos == home_pos(mode_e'(mode_i)));
      drive_en_o <= enable_i;
    end
  end

  // checker: consecutive cycles with home held low
  logic [1:0] home_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            home_age_q <= '0;
    else if (home_ni)       home_age_q <= '0;
    else if (home_age_q != 2'd3) home_age_q <= home_age_q + 2'd1;
  end

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (set_a_o == '0 && set_b_o == '0 && !drive_en_o));

  p_home_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !home_ni && home_age_q != 2'd0 && $stable(mode_i) |=> at_home_o);
endmodule

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b0;
  logic dir_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] torque_i = 2'b00;
  logic home_ni = 1'b0;
  logic enable_i = 1'b1;
  logic signed [7:0] set_a_o, set_b_o;
  logic at_home_o, drive_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  stepper_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
    .mode_i(mode_i), .torque_i(torque_i), .home_ni(home_ni), .enable_i(enable_i),
    .set_a_o(set_a_o), .set_b_o(set_b_o), .at_home_o(at_home_o), .drive_en_o(drive_en_o)
  );

  typedef struct packed {
    logic              home;
    logic [1:0]        mode;
    logic [1:0]        tq;
    logic              dir;
    logic              en;
    logic [3:0]        n;
    logic signed [7:0] ea;
    logic signed [7:0] eb;
    logic              flag;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b01, 2'b00, 1'b0, 1'b1, 4'd0,  8'sd100,  8'sd0,    1'b1, 4'd4},  // R4 half home
    '{1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 4'd1,  8'sd71,   8'sd71,   1'b0, 4'd5},  // R5 first step
    '{1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 4'd1,  8'sd0,    8'sd100,  1'b0, 4'd1},  // R1 half stride
    '{1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 4'd1, -8'sd71,   8'sd71,   1'b0, 4'd6},  // R6 cos sign
    '{1'b0, 2'b01, 2'b00, 1'b1, 1'b1, 4'd1,  8'sd0,    8'sd100,  1'b0, 4'd7},  // R7 reverse
    '{1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 4'd0,  8'sd100, -8'sd100,  1'b1, 4'd4},  // R4 full home
    '{1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'd1,  8'sd100,  8'sd100,  1'b0, 4'd3},  // R3
    '{1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'd1, -8'sd100,  8'sd100,  1'b0, 4'd3},  // R3
    '{1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'd2,  8'sd100, -8'sd100,  1'b1, 4'd10}, // R10 wrap
    '{1'b1, 2'b11, 2'b00, 1'b0, 1'b1, 4'd3,  8'sd83,   8'sd56,   1'b0, 4'd2},  // R2 eight/quarter
    '{1'b1, 2'b10, 2'b00, 1'b1, 1'b1, 4'd1,  8'sd100, -8'sd10,   1'b0, 4'd2},  // R2 sixteen, wrap below 0
    '{1'b0, 2'b10, 2'b00, 1'b1, 1'b1, 4'd4,  8'sd88,  -8'sd47,   1'b0, 4'd6},  // R6
    '{1'b0, 2'b10, 2'b01, 1'b1, 1'b1, 4'd0,  8'sd66,  -8'sd35,   1'b0, 4'd9},  // R9 75
    '{1'b0, 2'b10, 2'b11, 1'b1, 1'b1, 4'd0,  8'sd17,  -8'sd9,    1'b0, 4'd9},  // R9 20
    '{1'b0, 2'b10, 2'b10, 1'b1, 1'b1, 4'd0,  8'sd44,  -8'sd23,   1'b0, 4'd9},  // R9 50
    '{1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 4'd4,  8'sd0,    8'sd0,    1'b0, 4'd8},  // R8 gated
    '{1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 4'd0,  8'sd100, -8'sd10,   1'b0, 4'd8},  // R8 resumed
    '{1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 4'd1,  8'sd100,  8'sd0,    1'b1, 4'd10}  // R10 stepped home
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input int hi);
    @(negedge clk_i);
    step_i = 1'b1;
    wait_clk(hi);
    step_i = 1'b0;
    wait_clk(3);
  endtask

  task automatic chk(input string tag, input logic signed [7:0] ea, input logic signed [7:0] eb,
                     input logic ef, input logic ed);
    n_chk++;
    if (set_a_o !== ea || set_b_o !== eb || at_home_o !== ef || drive_en_o !== ed) begin
      n_bad++;
      $display("FAIL %s: a=%0d b=%0d home=%0b en=%0b expected a=%0d b=%0d home=%0b en=%0b",
               tag, set_a_o, set_b_o, at_home_o, drive_en_o, ea, eb, ef, ed);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(3);
    chk("reset", 8'sd0, 8'sd0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    wait_clk(2);

    for (int i = 0; i < NV; i++) begin
      mode_i   = VECS[i].mode;
      torque_i = VECS[i].tq;
      dir_i    = VECS[i].dir;
      enable_i = VECS[i].en;
      if (VECS[i].home) begin
        home_ni = 1'b0;
        wait_clk(6);
        home_ni = 1'b1;
        wait_clk(2);
      end
      for (int k = 0; k < int'(VECS[i].n); k++) pulse(3);
      wait_clk(6);
      chk($sformatf("vec %0d R%0d", i, VECS[i].req), VECS[i].ea, VECS[i].eb,
          VECS[i].flag, VECS[i].en);
    end

    // R4: held home ignores step and dir; R9 scales the home vector
    mode_i = 2'b00; torque_i = 2'b11; home_ni = 1'b0; dir_i = 1'b1;
    wait_clk(6);
    pulse(3);
    dir_i = 1'b0;
    pulse(3);
    wait_clk(4);
    chk("R4 hold ignores step", 8'sd20, -8'sd20, 1'b1, 1'b1);

    // R11 latency from step_i rise to demand change
    mode_i = 2'b01; torque_i = 2'b00;
    wait_clk(4);
    home_ni = 1'b1;
    wait_clk(4);
    @(negedge clk_i);
    step_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R11 before third edge", 8'sd100, 8'sd0, 1'b1, 1'b1);
    @(negedge clk_i);
    chk("R11 at third edge", 8'sd71, 8'sd71, 1'b0, 1'b1);
    step_i = 1'b0;
    wait_clk(4);

    // R11 long high level counts once
    pulse(20);
    wait_clk(4);
    chk("R11 long pulse", 8'sd0, 8'sd100, 1'b0, 1'b1);

    // R1 half step: eight steps per cycle, six more returns home
    for (int k = 0; k < 6; k++) pulse(3);
    wait_clk(4);
    chk("R1 half cycle wrap", 8'sd100, 8'sd0, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule